// File: doc/BRIEF.md
# Sample-Domain Automatic Level Controller

This block limits the level of a stream of signed audio samples that arrive with a valid strobe once per sample period. It holds an attenuation code in 0.5 dB units and scales every sample by the matching gain. Each output sample appears one clock after its input. The current code is also visible as an output.

Attack and release behave differently. When a sample's magnitude is above the limit level, the block adds attenuation quickly, in single codes on a short fixed sample period. When samples are below the lower recovery level, it takes attenuation back slowly, two codes at a time. A recovery step waits for a zero crossing of the signal, and a timeout forces the step if no crossing comes. Between the two levels the gain is frozen.

After the enable bit is switched on, level control stays idle for an initialization interval whose length depends on a mode bit. The same mode bit selects how many quiet samples a recovery step waits for.

Top module: `sample_level_ctrl`

## Requirements
- R1: After synchronous reset, `att_code` is 0 and `out_valid` is 0.
- R2: `out_valid` equals `in_valid` one clock later. While `en` is 0, every valid sample leaves unchanged one clock later and `att_code` stays 0.
- R3: A 0-to-1 change of `en` starts an initialization interval of INIT_LONG valid samples (mode 0) or INIT_SHORT valid samples (mode 1). The mode is taken at the rising edge. During the interval `att_code` stays 0 whatever the input level.
- R4: In normal running, a valid sample is "loud" when |x| > `lim_level` (|-32768| counts as 32768). Every LIM_PERIOD-th consecutive loud valid sample raises `att_code` by exactly 1. Any valid sample that is not loud restarts this count.
- R5: `att_code` never exceeds ATT_MAX. Loud samples at ATT_MAX leave it there.
- R6: A valid sample with `rec_level` <= |x| <= `lim_level` leaves `att_code` unchanged. It also clears all step progress, both limiter and recovery.
- R7: A valid sample with |x| < `rec_level` is "quiet". After REC_LONG (mode 0) or REC_SHORT (mode 1) consecutive quiet samples, recovery is armed. The next quiet sample that is a zero crossing then lowers `att_code` by 2. A zero crossing is a sample equal to 0, or one whose sign bit (bit 15) differs from that of the previous valid sample.
- R8: Once recovery is armed, if ZC_TIMEOUT quiet samples pass without a zero crossing, the ZC_TIMEOUT-th of them forces the 2-code decrease. After any decrease, arming starts over.
- R9: A recovery step never takes `att_code` below 0. A step taken at code 1 gives 0.
- R10: The output sample is floor(x * M[k mod 12] / 2^(15 + k div 12)), where k is `att_code` before that sample's update and M[j] = round(32768 * 10^(-j/40)).
- R11: Clearing `en` makes `att_code` 0 at the next clock, and level control stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Level control enable |
| mode | input | 1 | Period select: 0 long, 1 short |
| lim_level | input | DATA_W | Magnitude above which limiting acts |
| rec_level | input | DATA_W | Magnitude below which recovery acts |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DATA_W | Signed scaled sample |
| att_code | output | ATT_W | Attenuation in 0.5 dB units |

## Verification
The bench targets the following corner cases:

- **Clamping at both ends.** A design that wraps would jump from the maximum code to 0 under sustained loud input, or to 63 when a recovery step starts at code 1.
- **The magnitude of -32768.** A design that takes it as negative or as 32767 would miss a limit step at a full-scale threshold.
- **The dead band.** A design that keeps counting there would fire a limiter or recovery step early once the level leaves the band.
- **Recovery gating.** Constant-sign quiet input tests the timeout. A design without it would never recover. A design with the wrong timeout length would step on the wrong sample.
- **The initialization interval, in both modes.** A design that samples the mode late, or counts clocks instead of valid samples, would release limiting too early or too late.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } slc_state_e;

  localparam int MANT_W    = 16;   // unsigned gain mantissa, 32768 means unity
  localparam int FRAC_BITS = 15;
  localparam int OCT_CODES = 12;   // 0.5 dB codes per 6 dB binary shift

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/slc_level_detect.sv
module slc_level_detect #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [DATA_W-1:0] lim_level,
  input  logic [DATA_W-1:0] rec_level,
  output logic              loud,
  output logic              quiet,
  output logic              zero_cross
);
  localparam int MAG_W = DATA_W + 1;

  logic [MAG_W-1:0] mag;
  logic             prev_neg;
  logic             cur_neg;

  assign cur_neg = in_sample[DATA_W-1];

  // magnitude is one bit wider so the most negative code maps to its true size
  always_comb begin
    if (cur_neg) mag = MAG_W'(0) - {1'b1, in_sample};
    else         mag = {1'b0, in_sample};
  end

  assign loud       = mag > {1'b0, lim_level};
  assign quiet      = mag < {1'b0, rec_level};
  assign zero_cross = (in_sample == '0) || (cur_neg != prev_neg);

  always_ff @(posedge clk) begin
    if (rst)           prev_neg <= 1'b0;
    else if (in_valid) prev_neg <= cur_neg;
  end

  assert_bands_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    (lim_level >= rec_level) |-> !(loud && quiet));
endmodule

// File: rtl/slc_gain_ctrl.sv
module slc_gain_ctrl
  import slc_pkg::*;
#(
  parameter int ATT_W      = 6,
  parameter int ATT_MAX    = 63,
  parameter int LIM_PERIOD = 2,
  parameter int REC_LONG   = 2048,
  parameter int REC_SHORT  = 512,
  parameter int INIT_LONG  = 2048,
  parameter int INIT_SHORT = 512,
  parameter int ZC_TIMEOUT = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode,
  input  logic             in_valid,
  input  logic             loud,
  input  logic             quiet,
  input  logic             zero_cross,
  output logic [ATT_W-1:0] att_code
);
  localparam int unsigned CNT_TOP = max3(max3(LIM_PERIOD, REC_LONG, REC_SHORT),
                                         max3(INIT_LONG, INIT_SHORT, ZC_TIMEOUT), 2);
  localparam int CNT_W = $clog2(CNT_TOP + 1);

  localparam logic [CNT_W-1:0] LIM_LAST   = CNT_W'(LIM_PERIOD - 1);
  localparam logic [CNT_W-1:0] RECL_LAST  = CNT_W'(REC_LONG - 1);
  localparam logic [CNT_W-1:0] RECS_LAST  = CNT_W'(REC_SHORT - 1);
  localparam logic [CNT_W-1:0] INITL_LAST = CNT_W'(INIT_LONG - 1);
  localparam logic [CNT_W-1:0] INITS_LAST = CNT_W'(INIT_SHORT - 1);
  localparam logic [CNT_W-1:0] TO_LAST    = CNT_W'(ZC_TIMEOUT - 1);
  localparam logic [ATT_W-1:0] ATT_TOP    = ATT_W'(ATT_MAX);

  slc_state_e       state;
  logic             en_q;
  logic             init_mode;
  logic [CNT_W-1:0] init_cnt;
  logic [CNT_W-1:0] lim_cnt;
  logic [CNT_W-1:0] rec_cnt;
  logic [CNT_W-1:0] to_cnt;
  logic             armed;
  logic [CNT_W-1:0] rec_last;
  logic [CNT_W-1:0] init_last;
  logic [ATT_W-1:0] att_up;
  logic [ATT_W-1:0] att_down;

  assign rec_last  = mode      ? RECS_LAST  : RECL_LAST;
  assign init_last = init_mode ? INITS_LAST : INITL_LAST;
  assign att_up    = (att_code >= ATT_TOP) ? ATT_TOP : att_code + ATT_W'(1);
  assign att_down  = (att_code >= ATT_W'(2)) ? att_code - ATT_W'(2) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      en_q      <= 1'b0;
      init_mode <= 1'b0;
      init_cnt  <= '0;
      lim_cnt   <= '0;
      rec_cnt   <= '0;
      to_cnt    <= '0;
      armed     <= 1'b0;
      att_code  <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        state    <= ST_OFF;
        att_code <= '0;
        init_cnt <= '0;
        lim_cnt  <= '0;
        rec_cnt  <= '0;
        to_cnt   <= '0;
        armed    <= 1'b0;
      end else if (!en_q) begin
        state     <= ST_INIT;
        init_mode <= mode;
        att_code  <= '0;
        init_cnt  <= '0;
        lim_cnt   <= '0;
        rec_cnt   <= '0;
        to_cnt    <= '0;
        armed     <= 1'b0;
      end else begin
        case (state)
          ST_INIT: begin
            if (in_valid) begin
              if (init_cnt >= init_last) begin
                state    <= ST_RUN;
                init_cnt <= '0;
              end else begin
                init_cnt <= init_cnt + CNT_W'(1);
              end
            end
          end
          ST_RUN: begin
            if (in_valid) begin
              if (loud) begin
                rec_cnt <= '0;
                to_cnt  <= '0;
                armed   <= 1'b0;
                if (lim_cnt >= LIM_LAST) begin
                  lim_cnt  <= '0;
                  att_code <= att_up;
                end else begin
                  lim_cnt <= lim_cnt + CNT_W'(1);
                end
              end else if (quiet) begin
                lim_cnt <= '0;
                if (!armed) begin
                  if (rec_cnt >= rec_last) begin
                    armed   <= 1'b1;
                    rec_cnt <= '0;
                  end else begin
                    rec_cnt <= rec_cnt + CNT_W'(1);
                  end
                end else if (zero_cross || to_cnt >= TO_LAST) begin
                  att_code <= att_down;
                  armed    <= 1'b0;
                  to_cnt   <= '0;
                end else begin
                  to_cnt <= to_cnt + CNT_W'(1);
                end
              end else begin
                lim_cnt <= '0;
                rec_cnt <= '0;
                to_cnt  <= '0;
                armed   <= 1'b0;
              end
            end
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  assert_up_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (att_code > $past(att_code)) |-> (att_code == $past(att_code) + ATT_W'(1)));

  assert_down_two_or_floor_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && att_code < $past(att_code)) |->
      (($past(att_code) - att_code == ATT_W'(2)) || att_code == '0));

  assert_hold_at_max_R5: assert property (@(posedge clk) disable iff (rst)
    (en && att_code == ATT_TOP && in_valid && loud) |=> (att_code == ATT_TOP));

  assert_dead_band_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (en && in_valid && !loud && !quiet) |=> $stable(att_code));

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (att_code == '0));

  assert_init_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !en_q) |=> (att_code == '0 && state == ST_INIT));
endmodule

// File: rtl/slc_gain_rom.sv
module slc_gain_rom
  import slc_pkg::*;
#(
  parameter int ATT_W = 6,
  parameter int SH_W  = 3
) (
  input  logic [ATT_W-1:0]  code,
  output logic [MANT_W-1:0] mant,
  output logic [SH_W-1:0]   shift
);
  logic [3:0] idx;
  int         code_i;

  assign code_i = int'(code);
  assign idx    = 4'(code_i % OCT_CODES);
  assign shift  = SH_W'(code_i / OCT_CODES);

  // one 6 dB span of mantissas in 0.5 dB steps; larger codes add binary shifts
  always_comb begin
    case (idx)
      4'd0:    mant = 16'd32768;
      4'd1:    mant = 16'd30935;
      4'd2:    mant = 16'd29205;
      4'd3:    mant = 16'd27571;
      4'd4:    mant = 16'd26029;
      4'd5:    mant = 16'd24573;
      4'd6:    mant = 16'd23198;
      4'd7:    mant = 16'd21900;
      4'd8:    mant = 16'd20675;
      4'd9:    mant = 16'd19519;
      4'd10:   mant = 16'd18427;
      4'd11:   mant = 16'd17396;
      default: mant = 16'd32768;
    endcase
  end
endmodule

// File: rtl/slc_scaler.sv
module slc_scaler
  import slc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [MANT_W-1:0] mant,
  input  logic [SH_W-1:0]   shift,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);
  localparam int PROD_W = DATA_W + MANT_W + 1;
  localparam int SHT_W  = $clog2(FRAC_BITS + (1 << SH_W) + 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic [SHT_W-1:0]         total_shift;

  assign prod        = PROD_W'($signed(in_sample)) * PROD_W'($signed({1'b0, mant}));
  assign total_shift = SHT_W'(FRAC_BITS) + SHT_W'(shift);
  assign scaled      = prod >>> total_shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= scaled[DATA_W-1:0];
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> $stable(out_sample));
endmodule

// File: rtl/sample_level_ctrl.sv
module sample_level_ctrl
  import slc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ATT_W      = 6,
  parameter int ATT_MAX    = 63,
  parameter int LIM_PERIOD = 2,
  parameter int REC_LONG   = 2048,
  parameter int REC_SHORT  = 512,
  parameter int INIT_LONG  = 2048,
  parameter int INIT_SHORT = 512,
  parameter int ZC_TIMEOUT = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode,
  input  logic [DATA_W-1:0] lim_level,
  input  logic [DATA_W-1:0] rec_level,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample,
  output logic [ATT_W-1:0]  att_code
);
  localparam int SH_W = $clog2(((1 << ATT_W) - 1) / OCT_CODES + 1);

  logic              loud;
  logic              quiet;
  logic              zero_cross;
  logic [MANT_W-1:0] mant;
  logic [SH_W-1:0]   shift;

  slc_level_detect #(.DATA_W(DATA_W)) detect_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .lim_level  (lim_level),
    .rec_level  (rec_level),
    .loud       (loud),
    .quiet      (quiet),
    .zero_cross (zero_cross)
  );

  slc_gain_ctrl #(
    .ATT_W      (ATT_W),
    .ATT_MAX    (ATT_MAX),
    .LIM_PERIOD (LIM_PERIOD),
    .REC_LONG   (REC_LONG),
    .REC_SHORT  (REC_SHORT),
    .INIT_LONG  (INIT_LONG),
    .INIT_SHORT (INIT_SHORT),
    .ZC_TIMEOUT (ZC_TIMEOUT)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .mode       (mode),
    .in_valid   (in_valid),
    .loud       (loud),
    .quiet      (quiet),
    .zero_cross (zero_cross),
    .att_code   (att_code)
  );

  slc_gain_rom #(.ATT_W(ATT_W), .SH_W(SH_W)) rom_i (
    .code  (att_code),
    .mant  (mant),
    .shift (shift)
  );

  slc_scaler #(.DATA_W(DATA_W), .SH_W(SH_W)) scale_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .mant       (mant),
    .shift      (shift),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (att_code == '0 && !out_valid));
endmodule

// File: tb/sample_level_ctrl_tb_top.sv
`timescale 1ns/1ps
module sample_level_ctrl_tb_top;
  localparam int LP = 2, RL = 16, RS = 8, IL = 32, IS = 8, TO = 12, AMAX = 63;

  logic clk = 1'b0;
  logic rst, en, mode, in_valid, out_valid;
  logic [15:0] lim_level, rec_level, in_sample, out_sample;
  logic [5:0] att_code;

  always #10 clk = ~clk;

  sample_level_ctrl #(
    .DATA_W(16), .ATT_W(6), .ATT_MAX(AMAX), .LIM_PERIOD(LP), .REC_LONG(RL),
    .REC_SHORT(RS), .INIT_LONG(IL), .INIT_SHORT(IS), .ZC_TIMEOUT(TO)
  ) dut_i (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .lim_level(lim_level),
    .rec_level(rec_level), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample), .att_code(att_code)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference state, kept from the requirements
  int m_st, m_enq, m_imode, m_init, m_lim, m_rec, m_to, m_armed, m_att, m_prevneg;
  int e_valid, e_sample;

  function automatic int scale_ref(int x, int k);
    longint m, p;
    m = longint'($rtoi(32768.0 * $pow(10.0, -(k % 12) / 40.0) + 0.5));
    p = longint'(x) * m;
    return int'(p >>> (15 + k / 12));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_lim = 0; m_rec = 0; m_to = 0; m_armed = 0;
  endtask

  task automatic model_step(int e, int md, int v, int x, int lim, int rec);
    int mag, loud, quiet, zc;
    e_valid = v;
    if (v != 0) e_sample = scale_ref(x, m_att);
    mag   = (x < 0) ? -x : x;
    loud  = (mag > lim) ? 1 : 0;
    quiet = (mag < rec) ? 1 : 0;
    zc    = (x == 0 || (x < 0) != (m_prevneg != 0)) ? 1 : 0;
    if (e == 0) begin
      m_st = 0; m_att = 0; m_init = 0; model_clear();
    end else if (m_enq == 0) begin
      m_st = 1; m_imode = md; m_att = 0; m_init = 0; model_clear();
    end else if (m_st == 1) begin
      if (v != 0) begin
        if (m_init == ((m_imode != 0) ? IS : IL) - 1) begin m_st = 2; m_init = 0; end
        else m_init++;
      end
    end else if (m_st == 2 && v != 0) begin
      if (loud != 0) begin
        m_rec = 0; m_to = 0; m_armed = 0;
        if (m_lim == LP - 1) begin m_lim = 0; if (m_att < AMAX) m_att++; end
        else m_lim++;
      end else if (quiet != 0) begin
        m_lim = 0;
        if (m_armed == 0) begin
          if (m_rec >= ((md != 0) ? RS : RL) - 1) begin m_armed = 1; m_rec = 0; end
          else m_rec++;
        end else if (zc != 0 || m_to == TO - 1) begin
          m_att = (m_att >= 2) ? m_att - 2 : 0; m_armed = 0; m_to = 0;
        end else m_to++;
      end else model_clear();
    end
    m_enq = e;
    if (v != 0) m_prevneg = (x < 0) ? 1 : 0;
  endtask

  // drive one clock of stimulus at a falling edge, compare after the next rising edge
  task automatic cyc(string tag, int e, int md, int v, int x, int lim, int rec);
    en = e[0]; mode = md[0]; in_valid = v[0]; in_sample = 16'(x);
    lim_level = 16'(lim); rec_level = 16'(rec);
    model_step(e, md, v, x, lim, rec);
    @(negedge clk);
    chk(tag, "out_valid", int'(out_valid), e_valid);
    if (e_valid != 0) chk(tag, "out_sample", int'($signed(out_sample)), e_sample);
    chk(tag, "att_code", int'(att_code), m_att);
  endtask

  localparam int LIM = 16000, REC = 12700;

  initial begin
    rst = 1; en = 0; mode = 0; in_valid = 0; in_sample = 0;
    lim_level = 16'(LIM); rec_level = 16'(REC);
    m_st = 0; m_enq = 0; m_imode = 0; m_init = 0; m_att = 0; m_prevneg = 0;
    e_valid = 0; e_sample = 0; model_clear();
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1", "att_code after reset", int'(att_code), 0);
    chk("R1", "out_valid after reset", int'(out_valid), 0);

    // disabled: pass-through with gaps in the strobe
    for (int i = 0; i < 60; i++)
      cyc("R2", 0, 0, (i % 3 != 2) ? 1 : 0, int'($urandom_range(0, 65535)) - 32768, LIM, REC);

    // long initialization under full-scale input, strobe gaps included
    for (int i = 0; i < IL + 10; i++)
      cyc("R3", 1, 0, (i % 4 != 3) ? 1 : 0, (i % 2 == 0) ? -32768 : 30000, LIM, REC);
    chk("R3", "att stays zero through init", int'(att_code), 0);
    for (int i = 0; i < 6; i++) cyc("R3", 1, 0, 1, 30000, LIM, REC);

    // limiter ramp, including the -32768 magnitude against a full-scale threshold
    for (int i = 0; i < 8; i++) cyc("R4", 1, 0, 1, -32768, 32767, REC);
    for (int i = 0; i < 100; i++) cyc("R4", 1, 0, (i % 5 != 4) ? 1 : 0, 20000, LIM, REC);
    for (int i = 0; i < 80; i++) cyc("R5", 1, 0, 1, -25000, LIM, REC);
    chk("R5", "att clamps at max", int'(att_code), AMAX);
    for (int i = 0; i < 10; i++) cyc("R5", 1, 0, 1, 32767, LIM, REC);

    // dead band, both signs and both edges of the band
    for (int i = 0; i < 40; i++)
      cyc("R6", 1, 1, 1, (i % 2 == 0) ? REC : -LIM, LIM, REC);
    chk("R6", "att held in dead band", int'(att_code), AMAX);

    // recovery on zero crossings, short then long period
    for (int i = 0; i < 60; i++) cyc("R7", 1, 1, 1, (i % 2 == 0) ? 1000 : -1000, LIM, REC);
    for (int i = 0; i < 60; i++) cyc("R7", 1, 0, 1, (i % 3 == 0) ? 0 : 700, LIM, REC);

    // recovery by timeout with no crossing, down to the floor
    for (int i = 0; i < 700; i++) cyc("R8", 1, 1, (i % 7 != 6) ? 1 : 0, 500, LIM, REC);
    chk("R9", "att floors at zero", int'(att_code), 0);
    for (int i = 0; i < 40; i++) cyc("R9", 1, 1, 1, (i % 2 == 0) ? 3 : -3, LIM, REC);

    // sweep: mixed levels, strobe and mode; every code reached is checked for scaling
    for (int i = 0; i < 4000; i++) begin
      int r, x, md;
      r = int'($urandom_range(0, 99));
      if (r < 45)      x = int'($urandom_range(LIM + 1, 32768));
      else if (r < 65) x = int'($urandom_range(REC, LIM));
      else             x = int'($urandom_range(0, REC - 1));
      if ($urandom_range(0, 1) == 1) x = -x;
      if (x > 32767) x = 32767;
      md = ((i / 300) % 2);
      cyc("R10", 1, md, ($urandom_range(0, 3) != 0) ? 1 : 0, x, LIM, REC);
    end

    // disable from a nonzero code, then re-enable in short mode
    for (int i = 0; i < 30; i++) cyc("R11", 1, 0, 1, 31000, LIM, REC);
    cyc("R11", 0, 0, 1, 31000, LIM, REC);
    chk("R11", "att cleared on disable", int'(att_code), 0);
    for (int i = 0; i < 5; i++) cyc("R11", 0, 0, 1, -31000, LIM, REC);
    for (int i = 0; i < IS + 12; i++) cyc("R3", 1, 1, 1, 31000, LIM, REC);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule